// File: doc/BRIEF.md
# Typed Interrupt Source Bank

This block holds a bank of interrupt sources. Each source has a 32-bit configuration word and its own pending and activity state. Every source belongs to one of three classes that are fixed at elaboration. A normal source lets software pick level or edge triggering and the input polarity. An internal source is always level-triggered, and software may still pick its polarity. A special source, used for timers and inter-processor signalling, is always edge-triggered and takes its input without inversion. After every write the class forces the bits that software may not own.

Software changes a source's configuration through a one-cycle write strobe. Raw interrupt wires enter on a vector, one bit per source. A CPU acknowledges a source by giving the source index and its own CPU number. The last group of special sources carries inter-processor messages. Each of these keeps a mask of destination CPUs. After an acknowledge it raises itself again while any destination is still waiting. Arbitration between sources and delivery to CPUs happen outside this block. The block presents pending and activity flags, plus a combinational read port that returns one source's word, trigger mode and destination mask.

Top module: `tisc_top`

## Requirements
- R1: After reset, every source's word equals the reset parameter limited to its writable bits. Internal sources (index FIRST_INT up to FIRST_SPC-1) also have polarity bit 23 set. All pending flags, activity flags and destination masks are zero.
- R2: A write stores only mask bit 31, polarity bit 23, sense bit 22, priority bits 19:16 and the bits of 15:0 allowed by the vector-mask parameter. All other bits read as zero, and activity bit 30 keeps its value across a write.
- R3: A normal source (index below FIRST_INT) is level-triggered when sense bit 22 is 1 and edge-triggered when it is 0. The read port's level flag reports this mode.
- R4: After a write to an internal source, sense bit 22 reads as 0, and the source stays level-triggered.
- R5: After a write to a special source (index FIRST_SPC and up), bits 23 and 22 read as 0. The source is edge-triggered and uses its raw input without inversion.
- R6: For normal and internal sources, polarity bit 23 = 1 means the input is active-high and 0 means active-low.
- R7: A level-triggered source's pending flag equals its effective input one cycle later. Its activity equals pending with mask bit 31 clear.
- R8: An edge-triggered source's pending and activity are set in the next cycle by a rising effective input while mask bit 31 is 0. A rising input while masked is lost.
- R9: An acknowledge to an edge-triggered source clears its pending and activity flags. An acknowledge to a level-triggered source changes nothing.
- R10: A send to inter-processor source k (index N_SRC-N_IPI+k) ORs the given CPU mask into its destination mask. It also raises pending and activity if the source is unmasked.
- R11: An acknowledge by CPU c to an inter-processor source clears bit c of its destination mask. If bits remain, the source is raised again (pending and activity stay set while unmasked). Otherwise pending and activity clear.
- R12: The read port returns the selected source's word with activity in bit 30, its trigger mode, and its destination mask (zero for sources that are not inter-processor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Source written |
| wr_data | input | 32 | Word written |
| irq_in | input | N_SRC | Raw interrupt inputs |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Source acknowledged |
| ack_cpu | input | CPU_W | Acknowledging CPU |
| ipi_send_en | input | 1 | Inter-processor send strobe |
| ipi_send_sel | input | IPI_W | Inter-processor source selected within its group |
| ipi_send_mask | input | N_CPU | Destination CPUs added |
| rd_idx | input | IDX_W | Source read |
| rd_data | output | 32 | Word of the source read, with activity |
| rd_level | output | 1 | 1 when the source read is level-triggered |
| rd_dest | output | N_CPU | Destination mask of the source read |
| pending | output | N_SRC | Pending flag per source |
| active | output | N_SRC | Activity flag per source |

## Verification
The bench goes after the write that lands on a source with an input already raised. A design that applied the new polarity or mask in the same cycle would set or drop pending one cycle early. It also checks that a write leaves activity alone; a design that stored bit 30 from the bus would clear in-flight activity. For inter-processor sources it acknowledges one CPU at a time. A design that cleared on the first acknowledge would lose the second CPU, and one that never re-raised would leave pending stuck. Masked edges and acknowledges to level sources are driven too, to catch a design that latches a masked edge or lets an acknowledge clear a level source.

// File: rtl/tisc_pkg.sv
`timescale 1ns/1ps
package tisc_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL   = 2'd0,
        CLS_INTERNAL = 2'd1,
        CLS_SPECIAL  = 2'd2
    } src_cls_e;

    localparam int BIT_MASK  = 31;
    localparam int BIT_ACT   = 30;
    localparam int BIT_POL   = 23;
    localparam int BIT_SENSE = 22;
    localparam int PRI_LO    = 16;
    localparam int PRI_HI    = 19;

    // Bits that software is allowed to hold in a configuration word.
    function automatic logic [31:0] writable_bits(logic [15:0] vec_mask);
        logic [31:0] m;
        m                = '0;
        m[BIT_MASK]      = 1'b1;
        m[BIT_POL]       = 1'b1;
        m[BIT_SENSE]     = 1'b1;
        m[PRI_HI:PRI_LO] = '1;
        m[15:0]          = vec_mask;
        return m;
    endfunction

    // Class-imposed clean-up applied after a write.
    function automatic logic [31:0] class_fix(logic [31:0] v, src_cls_e c);
        logic [31:0] r;
        r = v;
        case (c)
            CLS_INTERNAL: r[BIT_SENSE] = 1'b0;
            CLS_SPECIAL: begin
                r[BIT_SENSE] = 1'b0;
                r[BIT_POL]   = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tisc_cfg_slot.sv
`timescale 1ns/1ps
module tisc_cfg_slot
    import tisc_pkg::*;
#(
    parameter src_cls_e    CLS       = CLS_NORMAL,
    parameter logic [31:0] RESET_VAL = 32'h8080_0000,
    parameter logic [15:0] VEC_MASK  = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [31:0] wr_data,
    input  logic        raw_in,
    output logic [31:0] word,
    output logic        level,
    output logic        masked,
    output logic        eff
);

    localparam logic [31:0] WMASK    = writable_bits(VEC_MASK);
    localparam logic [31:0] BASE_RST = RESET_VAL & WMASK;
    localparam logic [31:0] RST_WORD = (CLS == CLS_INTERNAL) ?
                                       (BASE_RST | (32'd1 << BIT_POL)) : BASE_RST;

    typedef struct packed {
        logic [31:0] word;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hit) begin
            s_d.word = class_fix(wr_data & WMASK, CLS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.word <= RST_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    assign word   = s_q.word;
    assign masked = s_q.word[BIT_MASK];

    always_comb begin
        case (CLS)
            CLS_INTERNAL: level = 1'b1;
            CLS_SPECIAL:  level = 1'b0;
            default:      level = s_q.word[BIT_SENSE];
        endcase
        if (CLS == CLS_SPECIAL) begin
            eff = raw_in;
        end else begin
            eff = s_q.word[BIT_POL] ? raw_in : ~raw_in;
        end
    end

endmodule

// File: rtl/tisc_src_state.sv
`timescale 1ns/1ps
module tisc_src_state (
    input  logic clk,
    input  logic rst_n,
    input  logic eff,
    input  logic level,
    input  logic masked,
    input  logic ack_hit,
    input  logic kick,
    output logic pending,
    output logic active,
    output logic rise
);

    typedef struct packed {
        logic pend;
        logic act;
        logic prev;
    } st_t;

    st_t s_d, s_q;

    assign rise = eff & ~s_q.prev;

    always_comb begin
        s_d      = s_q;
        s_d.prev = eff;
        if (level) begin
            s_d.pend = eff;
            s_d.act  = eff & ~masked;
        end else begin
            if (ack_hit) begin
                s_d.pend = 1'b0;
                s_d.act  = 1'b0;
            end
            if ((rise | kick) & ~masked) begin
                s_d.pend = 1'b1;
                s_d.act  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending = s_q.pend;
    assign active  = s_q.act;

endmodule

// File: rtl/tisc_ipi_dest.sv
`timescale 1ns/1ps
module tisc_ipi_dest #(
    parameter int N_CPU = 4,
    parameter int CPU_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_hit,
    input  logic [N_CPU-1:0] send_mask,
    input  logic             ack_hit,
    input  logic [CPU_W-1:0] ack_cpu,
    output logic [N_CPU-1:0] dest,
    output logic             kick
);

    typedef struct packed {
        logic [N_CPU-1:0] dest;
    } dst_t;

    dst_t s_d, s_q;
    logic [N_CPU-1:0] ack_bit;
    logic [N_CPU-1:0] remain;

    always_comb begin
        ack_bit  = ack_hit ? (N_CPU'(1) << ack_cpu) : '0;
        remain   = s_q.dest & ~ack_bit;
        s_d.dest = remain | (send_hit ? send_mask : '0);
        kick     = send_hit | (ack_hit & (|remain));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dest = s_q.dest;

endmodule

// File: rtl/tisc_top.sv
`timescale 1ns/1ps
module tisc_top
    import tisc_pkg::*;
#(
    parameter int          N_SRC     = 24,
    parameter int          FIRST_INT = 16,
    parameter int          FIRST_SPC = 20,
    parameter int          N_IPI     = 2,
    parameter int          N_CPU     = 4,
    parameter logic [31:0] RESET_VAL = 32'h8080_0000,
    parameter logic [15:0] VEC_MASK  = 16'h00FF,
    localparam int         IDX_W     = $clog2(N_SRC),
    localparam int         CPU_W     = $clog2(N_CPU),
    localparam int         IPI_W     = (N_IPI > 1) ? $clog2(N_IPI) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             ack_en,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic [CPU_W-1:0] ack_cpu,
    input  logic             ipi_send_en,
    input  logic [IPI_W-1:0] ipi_send_sel,
    input  logic [N_CPU-1:0] ipi_send_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             rd_level,
    output logic [N_CPU-1:0] rd_dest,
    output logic [N_SRC-1:0] pending,
    output logic [N_SRC-1:0] active
);

    localparam int IPI_BASE = N_SRC - N_IPI;

    logic [31:0]            cfg_arr [N_SRC];
    logic [N_SRC-1:0]       level_v;
    logic [N_SRC-1:0]       mask_v;
    logic [N_SRC-1:0]       eff_v;
    logic [N_SRC-1:0]       rise_v;
    logic [N_SRC-1:0]       sense_v;
    logic [N_SRC-1:0]       kick_v;
    logic [N_IPI*N_CPU-1:0] dest_flat;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam src_cls_e C = (i >= FIRST_SPC) ? CLS_SPECIAL :
                                 (i >= FIRST_INT) ? CLS_INTERNAL : CLS_NORMAL;
        logic wr_hit;
        logic ack_hit;

        assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(i));
        assign ack_hit = ack_en && (ack_idx == IDX_W'(i));

        tisc_cfg_slot #(
            .CLS       (C),
            .RESET_VAL (RESET_VAL),
            .VEC_MASK  (VEC_MASK)
        ) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .wr_data (wr_data),
            .raw_in  (irq_in[i]),
            .word    (cfg_arr[i]),
            .level   (level_v[i]),
            .masked  (mask_v[i]),
            .eff     (eff_v[i])
        );

        tisc_src_state u_state (
            .clk     (clk),
            .rst_n   (rst_n),
            .eff     (eff_v[i]),
            .level   (level_v[i]),
            .masked  (mask_v[i]),
            .ack_hit (ack_hit),
            .kick    (kick_v[i]),
            .pending (pending[i]),
            .active  (active[i]),
            .rise    (rise_v[i])
        );

        assign sense_v[i] = cfg_arr[i][BIT_SENSE];

        if (i >= IPI_BASE) begin : g_ipi
            logic send_hit;
            assign send_hit = ipi_send_en && (ipi_send_sel == IPI_W'(i - IPI_BASE));

            tisc_ipi_dest #(
                .N_CPU (N_CPU),
                .CPU_W (CPU_W)
            ) u_dest (
                .clk       (clk),
                .rst_n     (rst_n),
                .send_hit  (send_hit),
                .send_mask (ipi_send_mask),
                .ack_hit   (ack_hit),
                .ack_cpu   (ack_cpu),
                .dest      (dest_flat[(i-IPI_BASE)*N_CPU +: N_CPU]),
                .kick      (kick_v[i])
            );
        end else begin : g_plain
            assign kick_v[i] = 1'b0;
        end
    end

    always_comb begin
        rd_data  = '0;
        rd_level = 1'b0;
        rd_dest  = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data          = cfg_arr[k];
                rd_data[BIT_ACT] = active[k];
                rd_level         = level_v[k];
            end
        end
        for (int j = 0; j < N_IPI; j++) begin
            if (rd_idx == IDX_W'(IPI_BASE + j)) begin
                rd_dest = dest_flat[j*N_CPU +: N_CPU];
            end
        end
    end

endmodule

// File: rtl/tisc_chk.sv
`timescale 1ns/1ps
module tisc_chk #(
    parameter int  N_SRC     = 24,
    parameter int  FIRST_INT = 16,
    parameter int  N_IPI     = 2,
    parameter int  N_CPU     = 4,
    localparam int IDX_W     = $clog2(N_SRC),
    localparam int CPU_W     = $clog2(N_CPU),
    localparam int IPI_W     = (N_IPI > 1) ? $clog2(N_IPI) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ack_en,
    input logic [IDX_W-1:0]       ack_idx,
    input logic [CPU_W-1:0]       ack_cpu,
    input logic                   ipi_send_en,
    input logic [IPI_W-1:0]       ipi_send_sel,
    input logic [N_SRC-1:0]       pending,
    input logic [N_SRC-1:0]       active,
    input logic [N_SRC-1:0]       level_v,
    input logic [N_SRC-1:0]       mask_v,
    input logic [N_SRC-1:0]       eff_v,
    input logic [N_SRC-1:0]       rise_v,
    input logic [N_SRC-1:0]       sense_v,
    input logic [N_IPI*N_CPU-1:0] dest_flat
);

    localparam int IPI_BASE = N_SRC - N_IPI;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        // activity never stands without pending (R7, R8)
        assert_act_in_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
            active[i] |-> pending[i]);

        assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            level_v[i] |=> (pending[i] == $past(eff_v[i])));

        assert_masked_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!level_v[i] && mask_v[i] && !pending[i]) |=> !pending[i]);

        if (i >= FIRST_INT) begin : g_fixed
            assert_sense_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !sense_v[i]);
        end

        if (i < IPI_BASE) begin : g_ack
            assert_edge_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_en && ack_idx == IDX_W'(i) && !level_v[i] && !rise_v[i])
                |=> !pending[i]);
        end
    end

    for (genvar j = 0; j < N_IPI; j++) begin : g_ipi
        for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
            assert_ipi_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_en && ack_idx == IDX_W'(IPI_BASE + j) && ack_cpu == CPU_W'(c) &&
                 !(ipi_send_en && ipi_send_sel == IPI_W'(j)))
                |=> !dest_flat[j*N_CPU + c]);
        end
    end

endmodule

bind tisc_top tisc_chk #(
    .N_SRC     (N_SRC),
    .FIRST_INT (FIRST_INT),
    .N_IPI     (N_IPI),
    .N_CPU     (N_CPU)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_en       (ack_en),
    .ack_idx      (ack_idx),
    .ack_cpu      (ack_cpu),
    .ipi_send_en  (ipi_send_en),
    .ipi_send_sel (ipi_send_sel),
    .pending      (pending),
    .active       (active),
    .level_v      (level_v),
    .mask_v       (mask_v),
    .eff_v        (eff_v),
    .rise_v       (rise_v),
    .sense_v      (sense_v),
    .dest_flat    (dest_flat)
);

// File: tb/test_tisc_top.sv
`timescale 1ns/1ps
module test_tisc_top;

    localparam int          NS = 24;
    localparam int          FI = 16;
    localparam int          FS = 20;
    localparam int          NI = 2;
    localparam int          NC = 4;
    localparam int          IB = NS - NI;
    localparam logic [31:0] RV = 32'h8000_0005;
    localparam logic [15:0] VM = 16'h00FF;
    localparam logic [31:0] WM = 32'h80CF_0000 | {16'h0, VM};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [NS-1:0] irq_in = '0;
    logic          ack_en = 1'b0;
    logic [4:0]    ack_idx = '0;
    logic [1:0]    ack_cpu = '0;
    logic          ipi_send_en = 1'b0;
    logic [0:0]    ipi_send_sel = '0;
    logic [NC-1:0] ipi_send_mask = '0;
    logic [4:0]    rd_idx = '0;
    logic [31:0]   rd_data;
    logic          rd_level;
    logic [NC-1:0] rd_dest;
    logic [NS-1:0] pending;
    logic [NS-1:0] active;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tisc_top #(
        .N_SRC (NS), .FIRST_INT (FI), .FIRST_SPC (FS), .N_IPI (NI),
        .N_CPU (NC), .RESET_VAL (RV), .VEC_MASK (VM)
    ) i_tisc_top (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_data (wr_data), .irq_in (irq_in), .ack_en (ack_en),
        .ack_idx (ack_idx), .ack_cpu (ack_cpu), .ipi_send_en (ipi_send_en),
        .ipi_send_sel (ipi_send_sel), .ipi_send_mask (ipi_send_mask),
        .rd_idx (rd_idx), .rd_data (rd_data), .rd_level (rd_level),
        .rd_dest (rd_dest), .pending (pending), .active (active)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0]   mcfg  [NS];
    bit            mpend [NS];
    bit            mact  [NS];
    bit            mprev [NS];
    logic [NC-1:0] mdest [NI];

    function automatic int kind(int i);
        if (i >= FS) return 2;
        if (i >= FI) return 1;
        return 0;
    endfunction

    function automatic bit is_lvl(int i);
        if (kind(i) == 0) return mcfg[i][22];
        return kind(i) == 1;
    endfunction

    function automatic bit eff_of(int i, bit raw);
        if (kind(i) == 2) return raw;
        return mcfg[i][23] ? raw : !raw;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                mcfg[i]  = (RV & WM) | ((kind(i) == 1) ? 32'h0080_0000 : 32'h0);
                mpend[i] = 0;
                mact[i]  = 0;
                mprev[i] = 0;
            end
            for (int j = 0; j < NI; j++) mdest[j] = '0;
        end else begin
            for (int i = 0; i < NS; i++) begin
                bit e, up, msk, hit, kickit;
                logic [31:0] v;
                e      = eff_of(i, irq_in[i]);
                up     = e && !mprev[i];
                msk    = mcfg[i][31];
                hit    = ack_en && (ack_idx == 5'(i));
                kickit = 0;
                if (i >= IB) begin
                    logic [NC-1:0] left;
                    bit sent;
                    left = mdest[i-IB];
                    if (hit) left[ack_cpu] = 1'b0;
                    sent = ipi_send_en && (int'(ipi_send_sel) == i - IB);
                    kickit = sent || (hit && left != '0);
                    mdest[i-IB] = left | (sent ? ipi_send_mask : '0);
                end
                if (is_lvl(i)) begin
                    mpend[i] = e;
                    mact[i]  = e && !msk;
                end else begin
                    if (hit) begin
                        mpend[i] = 0;
                        mact[i]  = 0;
                    end
                    if ((up || kickit) && !msk) begin
                        mpend[i] = 1;
                        mact[i]  = 1;
                    end
                end
                mprev[i] = e;
                if (wr_en && wr_idx == 5'(i)) begin
                    v = wr_data & WM;
                    if (kind(i) == 1) v[22] = 1'b0;
                    if (kind(i) == 2) v[23:22] = 2'b00;
                    mcfg[i] = v;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic expect_eq(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [NS-1:0] ep, ea;
        logic [31:0]   ed;
        logic [NC-1:0] edst;
        bit            el;
        for (int i = 0; i < NS; i++) begin
            ep[i] = mpend[i];
            ea[i] = mact[i];
        end
        ed = '0; el = 0; edst = '0;
        if (int'(rd_idx) < NS) begin
            ed     = mcfg[rd_idx];
            ed[30] = mact[rd_idx];
            el     = is_lvl(int'(rd_idx));
            if (int'(rd_idx) >= IB) edst = mdest[int'(rd_idx) - IB];
        end
        expect_eq("R7 R8 R9 R10 R11 pending vector", 32'(pending), 32'(ep));
        expect_eq("R7 R8 R9 R11 activity vector", 32'(active), 32'(ea));
        expect_eq("R2 R12 read word", rd_data, ed);
        expect_eq("R3 R12 read level", 32'(rd_level), 32'(el));
        expect_eq("R10 R12 read dest", 32'(rd_dest), 32'(edst));
    endtask

    task automatic cycle();
        @(negedge clk);
        compare_all();
        wr_en       = 1'b0;
        ack_en      = 1'b0;
        ipi_send_en = 1'b0;
    endtask

    task automatic do_write(int idx, logic [31:0] val);
        wr_en   = 1'b1;
        wr_idx  = 5'(idx);
        wr_data = val;
        rd_idx  = 5'(idx);
        cycle();
    endtask

    task automatic do_ack(int idx, int cpu);
        ack_en  = 1'b1;
        ack_idx = 5'(idx);
        ack_cpu = 2'(cpu);
        rd_idx  = 5'(idx);
        cycle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset words per class
        rd_idx = 5'd0;  cycle();
        expect_eq("R1 normal reset word", rd_data, 32'h8000_0005);
        expect_eq("R1 pending after reset", 32'(pending), 32'h0);
        rd_idx = 5'd16; cycle();
        expect_eq("R1 internal reset word", rd_data, 32'h8080_0005);
        rd_idx = 5'd21; cycle();
        expect_eq("R1 special reset word", rd_data, 32'h8000_0005);

        // R2, R3: write filtering and sense on a normal source
        do_write(3, 32'hFFFF_FFFF);
        expect_eq("R2 write filter", rd_data, 32'h80CF_00FF);
        expect_eq("R3 sense=1 level", 32'(rd_level), 32'd1);
        do_write(3, 32'h0080_0012);
        expect_eq("R3 sense=0 edge", 32'(rd_level), 32'd0);

        // R8: rising edge while unmasked
        irq_in[3] = 1'b1; cycle();
        expect_eq("R8 edge sets pending", 32'(pending[3]), 32'd1);
        expect_eq("R12 activity in word", rd_data, 32'h4080_0012);
        do_write(3, 32'h0080_0034);
        expect_eq("R2 write keeps activity", rd_data, 32'h4080_0034);
        do_ack(3, 0);
        expect_eq("R9 edge ack clears", 32'(pending[3]), 32'd0);

        // R8: masked edge lost; R6 active-low edge
        irq_in[5] = 1'b1; cycle();
        irq_in[5] = 1'b0; cycle();
        expect_eq("R8 masked edge lost", 32'(pending[5]), 32'd0);
        do_write(5, 32'h0000_0000);
        irq_in[5] = 1'b1; cycle();
        irq_in[5] = 1'b0; cycle();
        expect_eq("R6 active-low edge", 32'(pending[5]), 32'd1);

        // R4, R7, R6 on an internal source
        do_write(17, 32'hFFFF_FFFF);
        expect_eq("R4 sense forced 0", rd_data, 32'h808F_00FF);
        expect_eq("R4 always level", 32'(rd_level), 32'd1);
        irq_in[17] = 1'b1; cycle();
        expect_eq("R7 masked level pending", 32'(pending[17]), 32'd1);
        expect_eq("R7 masked level inactive", 32'(active[17]), 32'd0);
        do_write(17, 32'h0000_0001);
        cycle();
        expect_eq("R6 active-low level idle", 32'(pending[17]), 32'd0);
        irq_in[17] = 1'b0; cycle();
        expect_eq("R7 level active", 32'(active[17]), 32'd1);
        do_ack(17, 1);
        expect_eq("R9 level ack no effect", 32'(pending[17]), 32'd1);

        // R5: special source
        do_write(21, 32'hFFFF_FFFF);
        expect_eq("R5 sense and polarity cleared", rd_data, 32'h800F_00FF);
        expect_eq("R5 always edge", 32'(rd_level), 32'd0);
        do_write(21, 32'h0000_0009);
        irq_in[21] = 1'b1; cycle();
        expect_eq("R5 raw rising edge", 32'(pending[21]), 32'd1);

        // R10, R11: inter-processor
        do_write(22, 32'h0000_0007);
        ipi_send_en = 1'b1; ipi_send_sel = 1'b0; ipi_send_mask = 4'b0101;
        rd_idx = 5'd22; cycle();
        expect_eq("R10 send pending", 32'(pending[22]), 32'd1);
        expect_eq("R10 send dest", 32'(rd_dest), 32'h5);
        do_ack(22, 0);
        expect_eq("R11 re-raise", 32'(pending[22]), 32'd1);
        expect_eq("R11 dest after first ack", 32'(rd_dest), 32'h4);
        do_ack(22, 2);
        expect_eq("R11 last ack clears", 32'(pending[22]), 32'd0);
        expect_eq("R11 dest empty", 32'(rd_dest), 32'h0);
        ipi_send_en = 1'b1; ipi_send_sel = 1'b1; ipi_send_mask = 4'b0011;
        rd_idx = 5'd23; cycle();
        expect_eq("R10 masked send no pending", 32'(pending[23]), 32'd0);
        expect_eq("R10 masked send dest", 32'(rd_dest), 32'h3);

        // mixed traffic against the reference
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 5) == 0) begin
                wr_en   = 1'b1;
                wr_idx  = 5'($urandom_range(0, NS-1));
                wr_data = $urandom;
                if ($urandom_range(0, 3) != 0) wr_data[31] = 1'b0;
            end
            if ($urandom_range(0, 2) == 0)
                irq_in[$urandom_range(0, NS-1)] ^= 1'b1;
            if ($urandom_range(0, 4) == 0) begin
                ack_en  = 1'b1;
                ack_idx = 5'($urandom_range(0, NS-1));
                ack_cpu = 2'($urandom_range(0, NC-1));
            end
            if ($urandom_range(0, 7) == 0) begin
                ipi_send_en   = 1'b1;
                ipi_send_sel  = 1'($urandom_range(0, NI-1));
                ipi_send_mask = 4'($urandom);
            end
            rd_idx = 5'($urandom_range(0, NS-1));
            cycle();
        end

        done = 1'b1;
        finish_run();
    end

endmodule